// File: doc/BRIEF.md
# Sector Write-Protection Lock Controller

This block holds the write-protection state of every sector of a parallel NOR-style flash array (32 sectors by default, main and parameter sectors alike, each one entry of the table). Each sector has a lock bit and a lock-down bit. A command decoder outside the block presents one decoded operation per cycle (Set Lock, Clear Lock or Set Lock-Down) with a sector index. A write-protect level input, active low, decides whether lock-down is enforced, and its falling and rising edges re-lock and release locked-down sectors. The program/erase sequencer asks whether a target sector may be altered, and a query port returns the two lock configuration bits of any sector.

Each sector runs a small state machine with five named states. `ST_OPEN` means unlocked and not locked down. `ST_LOCKED` means locked and not locked down. `ST_LD_LOCKED` means locked down and locked, either by command or because it was already locked before the protect level fell. `ST_LD_OPEN` means locked down but unlocked, which is only reachable while protect is high. `ST_LD_FORCED` means locked down and locked by a falling protect edge while it was unlocked; it remembers the pre-override lock bit. The transitions are as follows. Set Lock moves `ST_OPEN`→`ST_LOCKED` and `ST_LD_OPEN`/`ST_LD_FORCED`→`ST_LD_LOCKED`. Set Lock-Down moves every state to `ST_LD_LOCKED`. Clear Lock moves `ST_LOCKED`→`ST_OPEN`, and moves `ST_LD_LOCKED`/`ST_LD_FORCED`→`ST_LD_OPEN` only with protect high. A protect fall moves `ST_LD_OPEN`→`ST_LD_FORCED`. A protect rise moves `ST_LD_FORCED`→`ST_LD_OPEN`. In any cycle the protect edge is applied first and the command second.

Top module: `sector_lock_ctrl`

## Requirements
- R1: After reset every sector reads as locked and not locked down (query value 2'b01).
- R2: Set Lock (opcode 2'b01) locks the named sector and leaves its lock-down bit unchanged.
- R3: Set Lock-Down (opcode 2'b11) sets both the lock-down bit and the lock bit of the named sector in the same clock edge, from any prior state.
- R4: Clear Lock (opcode 2'b10) with protect input low on a sector whose lock-down bit is set has no effect.
- R5: Clear Lock with protect input high unlocks the named sector even if it is locked down; its lock-down bit stays set.
- R6: Clear Lock on a sector that is not locked down unlocks it at either protect level.
- R7: On a high-to-low change of the protect input, every locked-down sector becomes locked, and other sectors are untouched.
- R8: On a low-to-high change of the protect input, a locked-down sector that was unlocked just before the preceding fall returns to unlocked. One that was locked before that fall, or that received Set Lock since the fall, stays locked.
- R9: Lock-down bits are cleared only by reset.
- R10: With a check request, the abort output is 1 and the allow output 0 when the target sector is locked or its index is out of range; with an unlocked in-range target, allow is 1 and abort 0; without a request both are 0. The outputs are combinational in the current state.
- R11: The query output gives bit 0 = lock (1 = locked) and bit 1 = lock-down (1 = locked down) for the queried sector, combinationally; an out-of-range index reads 2'b00.
- R12: A command naming a sector index at or above the sector count changes no state.
- R13: A command or a protect level change takes effect at the first rising clock edge at which it is presented, and not before; opcode 2'b00 means no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_level_i | input | 1 | Write-protect level; low enforces lock-down |
| cmd_op_i | input | 2 | Decoded operation: 00 none, 01 set lock, 10 clear lock, 11 set lock-down |
| cmd_sect_i | input | IDX_W | Sector index of the command |
| chk_req_i | input | 1 | Program/erase permission request |
| chk_sect_i | input | IDX_W | Sector index of the request |
| chk_abort_o | output | 1 | Request must be aborted (device-protect indication) |
| chk_allow_o | output | 1 | Request may proceed |
| qry_sect_i | input | IDX_W | Sector index of the configuration query |
| qry_cfg_o | output | 2 | {lock-down, lock} of the queried sector |

## Verification
A wrong sector state shows on the query port as a bad lock or lock-down bit at that sector's index. It also shows on the check outputs as a wrong abort/allow pair, one clock edge after the command or protect change that caused it. A lost pre-override memory is invisible until the protect level rises again, so the bench reads every sector after each fall and again after the following rise. Out-of-range commands could only corrupt the table, so the full table is read back after them.

// File: rtl/slk_pkg.sv
package slk_pkg;

    typedef enum logic [2:0] {
        ST_OPEN      = 3'd0,
        ST_LOCKED    = 3'd1,
        ST_LD_LOCKED = 3'd2,
        ST_LD_OPEN   = 3'd3,
        ST_LD_FORCED = 3'd4
    } sect_state_e;

    typedef enum logic [1:0] {
        OP_NONE      = 2'b00,
        OP_SET_LOCK  = 2'b01,
        OP_CLR_LOCK  = 2'b10,
        OP_SET_LDOWN = 2'b11
    } lock_op_e;

endpackage

// File: rtl/slk_wp_edge.sv
module slk_wp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic wp_i,
    output logic wp_fall_o,
    output logic wp_rise_o
);

    logic wp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) wp_q <= 1'b0;
        else        wp_q <= wp_i;
    end

    always_comb begin
        wp_fall_o = wp_q & ~wp_i;
        wp_rise_o = ~wp_q & wp_i;
    end

endmodule

// File: rtl/slk_cmd_decode.sv
module slk_cmd_decode #(
    parameter int NUM_SECT = 32,
    parameter int IDX_W    = 6
) (
    input  logic [1:0]          op_i,
    input  logic [IDX_W-1:0]    sect_i,
    output logic [NUM_SECT-1:0] hit_o,
    output logic                in_range_o
);

    localparam logic [31:0] NS32 = NUM_SECT;

    always_comb in_range_o = 32'(sect_i) < NS32;

    for (genvar gi = 0; gi < NUM_SECT; gi++) begin : g_hit
        assign hit_o[gi] = (op_i != 2'b00) && (sect_i == IDX_W'(gi));
    end

endmodule

// File: rtl/slk_sector_cell.sv
module slk_sector_cell
    import slk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hit_i,
    input  lock_op_e op_i,
    input  logic     wp_now_i,
    input  logic     wp_fall_i,
    input  logic     wp_rise_i,
    output logic     lock_o,
    output logic     ldown_o
);

    sect_state_e st_q, st_edge, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LOCKED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_edge = st_q;
        if (wp_fall_i && st_q == ST_LD_OPEN)   st_edge = ST_LD_FORCED;
        if (wp_rise_i && st_q == ST_LD_FORCED) st_edge = ST_LD_OPEN;
        st_d = st_edge;
        if (hit_i) begin
            unique case (op_i)
                OP_SET_LOCK: begin
                    unique case (st_edge)
                        ST_OPEN:                  st_d = ST_LOCKED;
                        ST_LD_OPEN, ST_LD_FORCED: st_d = ST_LD_LOCKED;
                        default:                  st_d = st_edge;
                    endcase
                end
                OP_SET_LDOWN: st_d = ST_LD_LOCKED;
                OP_CLR_LOCK: begin
                    unique case (st_edge)
                        ST_OPEN, ST_LOCKED: st_d = ST_OPEN;
                        default:            st_d = wp_now_i ? ST_LD_OPEN : st_edge;
                    endcase
                end
                default: st_d = st_edge;
            endcase
        end
    end

    always_comb begin
        lock_o  = 1'b0;
        ldown_o = 1'b0;
        unique case (st_q)
            ST_LOCKED:    lock_o = 1'b1;
            ST_LD_LOCKED: begin lock_o = 1'b1; ldown_o = 1'b1; end
            ST_LD_FORCED: begin lock_o = 1'b1; ldown_o = 1'b1; end
            ST_LD_OPEN:   ldown_o = 1'b1;
            default:      lock_o = 1'b0;
        endcase
    end

    a_r3_ldown_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && op_i == OP_SET_LDOWN) |=> (lock_o && ldown_o));

    a_r4_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && op_i == OP_CLR_LOCK && !wp_now_i && ldown_o) |=> (lock_o && ldown_o));

    a_r5_clear_overrides: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && op_i == OP_CLR_LOCK && wp_now_i) |=> !lock_o);

    a_r7_fall_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_fall_i && ldown_o) |=> lock_o);

    a_r9_ldown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ldown_o |=> ldown_o);

endmodule

// File: rtl/sector_lock_ctrl.sv
module sector_lock_ctrl
    import slk_pkg::*;
#(
    parameter int NUM_SECT = 32,
    parameter int IDX_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wp_level_i,
    input  logic [1:0]       cmd_op_i,
    input  logic [IDX_W-1:0] cmd_sect_i,
    input  logic             chk_req_i,
    input  logic [IDX_W-1:0] chk_sect_i,
    output logic             chk_abort_o,
    output logic             chk_allow_o,
    input  logic [IDX_W-1:0] qry_sect_i,
    output logic [1:0]       qry_cfg_o
);

    localparam int          SEL_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
    localparam logic [31:0] NS32  = NUM_SECT;

    logic [NUM_SECT-1:0] hit, lock_vec, ld_vec;
    logic                cmd_in_range, wp_fall, wp_rise;
    logic                chk_in_range, qry_in_range;
    lock_op_e            op;

    always_comb op = lock_op_e'(cmd_op_i);

    slk_wp_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .wp_i      (wp_level_i),
        .wp_fall_o (wp_fall),
        .wp_rise_o (wp_rise)
    );

    slk_cmd_decode #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W)) u_dec (
        .op_i       (cmd_op_i),
        .sect_i     (cmd_sect_i),
        .hit_o      (hit),
        .in_range_o (cmd_in_range)
    );

    for (genvar gs = 0; gs < NUM_SECT; gs++) begin : g_sect
        slk_sector_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (hit[gs]),
            .op_i      (op),
            .wp_now_i  (wp_level_i),
            .wp_fall_i (wp_fall),
            .wp_rise_i (wp_rise),
            .lock_o    (lock_vec[gs]),
            .ldown_o   (ld_vec[gs])
        );
    end

    always_comb begin
        chk_in_range = 32'(chk_sect_i) < NS32;
        qry_in_range = 32'(qry_sect_i) < NS32;
        chk_abort_o  = 1'b0;
        chk_allow_o  = 1'b0;
        if (chk_req_i) begin
            if (chk_in_range && !lock_vec[chk_sect_i[SEL_W-1:0]]) chk_allow_o = 1'b1;
            else                                                   chk_abort_o = 1'b1;
        end
        qry_cfg_o = 2'b00;
        if (qry_in_range)
            qry_cfg_o = {ld_vec[qry_sect_i[SEL_W-1:0]], lock_vec[qry_sect_i[SEL_W-1:0]]};
    end

    a_r12_oor_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op_i != 2'b00 && !cmd_in_range && !wp_fall && !wp_rise)
        |=> (lock_vec == $past(lock_vec) && ld_vec == $past(ld_vec)));

    a_r10_excl_result: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_abort_o && chk_allow_o));

    a_r10_req_answered: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req_i |-> (chk_abort_o || chk_allow_o));

endmodule

// File: tb/sector_lock_ctrl_bench.sv
`timescale 1ns/1ps
module sector_lock_ctrl_bench;

    localparam int NS = 32;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [IW-1:0] csect = '0;
    logic          creq = 1'b0;
    logic [IW-1:0] ksect = '0;
    logic          abort_w, allow_w;
    logic [IW-1:0] qsect = '0;
    logic [1:0]    cfg_w;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [NS-1:0] m_lock, m_ld, m_frc;

    always #2 clk = ~clk;

    sector_lock_ctrl #(.NUM_SECT(NS), .IDX_W(IW)) u_sector_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .wp_level_i(wp),
        .cmd_op_i(op), .cmd_sect_i(csect),
        .chk_req_i(creq), .chk_sect_i(ksect),
        .chk_abort_o(abort_w), .chk_allow_o(allow_w),
        .qry_sect_i(qsect), .qry_cfg_o(cfg_w)
    );

    task automatic chk(input string tag, input int got, input int exp, input int sect);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s sector %0d got %0d exp %0d", tag, sect, got, exp);
        end
    endtask

    task automatic model_reset();
        m_lock = '1; m_ld = '0; m_frc = '0;
    endtask

    task automatic do_cmd(input logic [1:0] o, input int s);
        @(negedge clk); op = o; csect = IW'(s);
        @(negedge clk); op = 2'b00;
        if (s < NS) begin
            case (o)
                2'b01: begin m_lock[s] = 1'b1; m_frc[s] = 1'b0; end
                2'b11: begin m_lock[s] = 1'b1; m_ld[s] = 1'b1; m_frc[s] = 1'b0; end
                2'b10: if (!m_ld[s] || wp) begin m_lock[s] = 1'b0; m_frc[s] = 1'b0; end
                default: ;
            endcase
        end
    endtask

    task automatic set_wp(input logic v);
        logic old;
        old = wp;
        @(negedge clk); wp = v;
        @(negedge clk);
        for (int i = 0; i < NS; i++) begin
            if (old && !v && m_ld[i]) begin m_frc[i] = !m_lock[i]; m_lock[i] = 1'b1; end
            if (!old && v && m_ld[i] && m_frc[i]) begin m_lock[i] = 1'b0; m_frc[i] = 1'b0; end
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < NS; i++) begin
            @(negedge clk); qsect = IW'(i); ksect = IW'(i); creq = 1'b1;
            #1;
            chk(tag, int'(cfg_w), int'({m_ld[i], m_lock[i]}), i);
            chk("R10", int'({abort_w, allow_w}), m_lock[i] ? 2 : 1, i);
        end
        @(negedge clk); creq = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");
        // R10: no request gives neither output
        @(negedge clk); creq = 1'b0; #1;
        chk("R10", int'({abort_w, allow_w}), 0, 0);
        // R6: clear with protect low on plain locked sectors
        for (int i = 0; i < NS; i += 3) do_cmd(2'b10, i);
        check_all("R6");
        // R3: lock-down on open and locked sectors
        for (int i = 0; i < NS; i += 4) do_cmd(2'b11, i);
        check_all("R3");
        // R2: set lock on open sectors
        for (int i = 3; i < NS; i += 6) do_cmd(2'b01, i);
        do_cmd(2'b01, 0);
        check_all("R2");
        // R4: clear blocked on locked-down sectors while protect low
        for (int i = 0; i < NS; i += 4) do_cmd(2'b10, i);
        check_all("R4");
        for (int i = 2; i < NS; i += 4) do_cmd(2'b10, i);
        check_all("R6");
        // R12: out-of-range commands
        for (int i = NS; i < (1 << IW); i += 5) begin
            do_cmd(2'b01, i); do_cmd(2'b10, i); do_cmd(2'b11, i);
        end
        check_all("R12");
        // R11/R10: out-of-range query and check
        for (int i = NS; i < (1 << IW); i += 7) begin
            @(negedge clk); qsect = IW'(i); ksect = IW'(i); creq = 1'b1; #1;
            chk("R11", int'(cfg_w), 0, i);
            chk("R10", int'({abort_w, allow_w}), 2, i);
        end
        @(negedge clk); creq = 1'b0;
        // R5: protect high, clear overrides lock-down
        set_wp(1'b1);
        check_all("R13");
        for (int i = 0; i < NS; i += 8) do_cmd(2'b10, i);
        check_all("R5");
        // R7: falling protect relocks locked-down sectors
        set_wp(1'b0);
        check_all("R7");
        do_cmd(2'b01, 8);
        // R8: rising protect restores pre-fall lock
        set_wp(1'b1);
        check_all("R8");
        // R13: command not visible before the clock edge
        @(negedge clk); op = 2'b10; csect = IW'(1); qsect = IW'(1); #1;
        chk("R13", int'(cfg_w), int'({m_ld[1], m_lock[1]}), 1);
        @(negedge clk); op = 2'b00; #1;
        chk("R13", int'(cfg_w), 0, 1);
        m_lock[1] = 1'b0;
        // R9: lock-down survives everything except reset
        set_wp(1'b0);
        for (int i = 0; i < NS; i += 4) do_cmd(2'b10, i);
        set_wp(1'b1);
        check_all("R9");
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_all("R9");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule